// File: doc/BRIEF.md
# Clock Failure Switchover Controller

This block sits beside a main-oscillator failure detector and drives the select and enable controls of a clock tree. Until a failure is reported, the main-clock select, the master-clock select and the 12 MHz RC oscillator enable pass straight from the software-programmed values to the outputs. When a failure is reported while the crystal feeds the main clock, the controller takes the tree back to the internal RC oscillator. It does this in steps, and each step waits for a rising edge of a slow reference clock.

If the master clock runs from a PLL at the time of the failure, the controller first points the master-clock select at the main clock. It then points the main-clock select at the RC oscillator. If the master clock already runs from the main clock, the first step is skipped. The RC oscillator enable is forced on as soon as the sequence starts. All overrides stay in force until reset, whatever software writes afterwards. The glitch-free multiplexers themselves are outside this block.

The slow reference is asynchronous to `clk_i`. It is synchronized internally and only its rising edges are used.

Top module: `clk_fail_switch`

## Requirements
- R1: After reset, `fail_o` and `done_o` are 0, and `main_sel_o`, `mck_sel_o` and `rc_en_o` equal `sw_main_sel_i`, `sw_mck_sel_i` and `sw_rc_en_i`.
- R2: `fail_o` goes to 1 once `fail_i` has been high for a `clk_i` cycle. It stays at 1 until reset, even after `fail_i` falls.
- R3: Main-clock select encoding is 1 = crystal and 0 = RC. With the crystal selected and `sw_mck_sel_i` at 0 or 1 when the failure is captured, `main_sel_o` becomes 0 after the second `ref_i` rising edge that follows the capture, and not after the first.
- R4: Master-clock select encoding is 0 = slow clock, 1 = main clock, 2 and 3 = PLLs. With the crystal selected and `sw_mck_sel_i` at 2 or 3 at capture, `mck_sel_o` becomes 1 after the second `ref_i` rising edge, while `main_sel_o` stays 1. `main_sel_o` becomes 0 after the third edge.
- R5: Once a switchover starts, `rc_en_o` is 1 from the first `ref_i` rising edge after capture, whatever the value of `sw_rc_en_i`.
- R6: After the sequence completes, changes on `sw_main_sel_i` and `sw_rc_en_i` do not change `main_sel_o` or `rc_en_o`. When the PLL path was taken, changes on `sw_mck_sel_i` do not change `mck_sel_o` either. This holds until reset.
- R7: If `sw_main_sel_i` is 0 (RC) when the failure is captured, no override is applied. The outputs keep following the software values, `done_o` stays 0 and `fail_o` is still 1.
- R8: `done_o` rises in the same cycle that the main-clock override takes effect, and it stays high until reset.
- R9: While no failure is latched, all three outputs follow their software inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Slow reference clock, asynchronous |
| fail_i | input | 1 | Failure indication from the detector |
| sw_main_sel_i | input | 1 | Software main-clock select (1 crystal, 0 RC) |
| sw_mck_sel_i | input | 2 | Software master-clock select |
| sw_rc_en_i | input | 1 | Software RC oscillator enable |
| main_sel_o | output | 1 | Effective main-clock select |
| mck_sel_o | output | 2 | Effective master-clock select |
| rc_en_o | output | 1 | Effective RC oscillator enable |
| fail_o | output | 1 | Latched failure report |
| done_o | output | 1 | Switchover complete |

## Verification
The hardest state to reach is the middle of the PLL path. There, the master-clock override is active but the main-clock override is not yet applied, and the state lasts for only one slow reference period. The bench drives `ref_i` one edge at a time and checks all outputs after each edge, so the second-edge state of the three-step path is observed directly. The RC-selected case is also hard to see, because nothing visible changes in it. The bench covers it by checking that the outputs keep tracking software while `fail_o` is set.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int unsigned MCK_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_FORCE_MCK  = 2'd1,
    ST_FORCE_MAIN = 2'd2,
    ST_DONE       = 2'd3
  } cfs_state_e;

  localparam logic             MAIN_SEL_RC   = 1'b0;
  localparam logic             MAIN_SEL_XTAL = 1'b1;
  localparam logic [MCK_W-1:0] MCK_SEL_MAIN  = 2'd1;
endpackage

// File: rtl/cfs_edge_sync.sv
module cfs_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned LEN = SYNC_STAGES + 1;

  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[LEN-2:0], async_i};
  end

  // the extra stage is the previous synchronized value
  assign rise_o = sr_q[LEN-2] & ~sr_q[LEN-1];
endmodule

// File: rtl/cfs_seq_fsm.sv
module cfs_seq_fsm
  import cfs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fail_i,
  input  logic xtal_sel_i,
  input  logic mck_pll_i,
  output logic fail_o,
  output logic force_mck_o,
  output logic force_main_o,
  output logic force_rc_o,
  output logic done_o
);
  cfs_state_e state_q, state_d;
  logic fail_q, armed_q, pll_q;
  logic force_mck_q, force_main_q;

  // path is fixed when the failure is first captured
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q  <= 1'b0;
      armed_q <= 1'b0;
      pll_q   <= 1'b0;
    end else if (fail_i && !fail_q) begin
      fail_q  <= 1'b1;
      armed_q <= xtal_sel_i;
      pll_q   <= mck_pll_i;
    end
  end

  always_comb begin
    state_d = state_q;
    if (tick_i) begin
      unique case (state_q)
        ST_IDLE:       if (armed_q) state_d = pll_q ? ST_FORCE_MCK : ST_FORCE_MAIN;
        ST_FORCE_MCK:  state_d = ST_FORCE_MAIN;
        ST_FORCE_MAIN: state_d = ST_DONE;
        default:       state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      force_mck_q  <= 1'b0;
      force_main_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (tick_i && state_q == ST_FORCE_MCK)  force_mck_q  <= 1'b1;
      if (tick_i && state_q == ST_FORCE_MAIN) force_main_q <= 1'b1;
    end
  end

  assign fail_o       = fail_q;
  assign force_mck_o  = force_mck_q;
  assign force_main_o = force_main_q;
  assign force_rc_o   = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
endmodule

// File: rtl/cfs_override.sv
module cfs_override #(
  parameter int unsigned     W     = 1,
  parameter logic [W-1:0]    VALUE = '0
) (
  input  logic         force_i,
  input  logic [W-1:0] sw_i,
  output logic [W-1:0] eff_o
);
  assign eff_o = force_i ? VALUE : sw_i;
endmodule

// File: rtl/clk_fail_switch.sv
module clk_fail_switch
  import cfs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             fail_i,
  input  logic             sw_main_sel_i,
  input  logic [MCK_W-1:0] sw_mck_sel_i,
  input  logic             sw_rc_en_i,
  output logic             main_sel_o,
  output logic [MCK_W-1:0] mck_sel_o,
  output logic             rc_en_o,
  output logic             fail_o,
  output logic             done_o
);
  logic tick;
  logic force_mck, force_main, force_rc;

  cfs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ref_i),
    .rise_o (tick)
  );

  cfs_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .fail_i      (fail_i),
    .xtal_sel_i  (sw_main_sel_i == MAIN_SEL_XTAL),
    .mck_pll_i   (sw_mck_sel_i[MCK_W-1]),
    .fail_o      (fail_o),
    .force_mck_o (force_mck),
    .force_main_o(force_main),
    .force_rc_o  (force_rc),
    .done_o      (done_o)
  );

  cfs_override #(.W(1), .VALUE(MAIN_SEL_RC)) u_ov_main (
    .force_i(force_main), .sw_i(sw_main_sel_i), .eff_o(main_sel_o)
  );

  cfs_override #(.W(MCK_W), .VALUE(MCK_SEL_MAIN)) u_ov_mck (
    .force_i(force_mck), .sw_i(sw_mck_sel_i), .eff_o(mck_sel_o)
  );

  cfs_override #(.W(1), .VALUE(1'b1)) u_ov_rc (
    .force_i(force_rc), .sw_i(sw_rc_en_i), .eff_o(rc_en_o)
  );
endmodule

// File: rtl/cfs_chk.sv
module cfs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sw_main_sel_i,
  input logic [1:0] sw_mck_sel_i,
  input logic       sw_rc_en_i,
  input logic       main_sel_o,
  input logic [1:0] mck_sel_o,
  input logic       rc_en_o,
  input logic       fail_o,
  input logic       done_o
);
  // R2
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o);
  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R8
  done_main_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (main_sel_o == 1'b0));
  // R5
  done_rc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rc_en_o);
  // R9
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fail_o |-> (main_sel_o == sw_main_sel_i && mck_sel_o == sw_mck_sel_i
                 && rc_en_o == sw_rc_en_i));
  // R8
  done_needs_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fail_o);
endmodule

bind clk_fail_switch cfs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sw_main_sel_i(sw_main_sel_i),
  .sw_mck_sel_i(sw_mck_sel_i), .sw_rc_en_i(sw_rc_en_i),
  .main_sel_o(main_sel_o), .mck_sel_o(mck_sel_o), .rc_en_o(rc_en_o),
  .fail_o(fail_o), .done_o(done_o)
);

// File: tb/sim_clk_fail_switch.sv
`timescale 1ns/1ps
module sim_clk_fail_switch;
  logic clk = 1'b0, rst_n = 1'b0, ref_c = 1'b0, fail = 1'b0;
  logic sw_main = 1'b1, sw_rc = 1'b0;
  logic [1:0] sw_mck = 2'd1;
  logic main_sel, rc_en, fail_o, done_o;
  logic [1:0] mck_sel;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  clk_fail_switch u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_c), .fail_i(fail),
    .sw_main_sel_i(sw_main), .sw_mck_sel_i(sw_mck), .sw_rc_en_i(sw_rc),
    .main_sel_o(main_sel), .mck_sel_o(mck_sel), .rc_en_o(rc_en),
    .fail_o(fail_o), .done_o(done_o)
  );

  // {sw_main, sw_mck, sw_rc, edges_to_done (0 = no action)}
  localparam logic [5:0] VEC [6] = '{
    {1'b1, 2'd1, 1'b1, 2'd2},
    {1'b1, 2'd0, 1'b0, 2'd2},
    {1'b1, 2'd2, 1'b0, 2'd3},
    {1'b1, 2'd3, 1'b1, 2'd3},
    {1'b0, 2'd2, 1'b0, 2'd0},
    {1'b0, 2'd1, 1'b1, 2'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_c = 1'b0; fail = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic raise_fail();
    @(negedge clk) fail = 1'b1;
    repeat (2) @(negedge clk);
    fail = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // one ref rising edge; sample after sync and FSM registers have settled
  task automatic ref_edge();
    @(negedge clk) ref_c = 1'b1;
    repeat (8) @(negedge clk);
    ref_c = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    sw_main = 1'b1; sw_mck = 2'd2; sw_rc = 1'b0;
    do_reset();
    @(negedge clk);
    chk("R1 fail_o", fail_o, 0);
    chk("R1 done_o", done_o, 0);
    chk("R1 main_sel", main_sel, 1);
    chk("R1 mck_sel", mck_sel, 2);
    chk("R1 rc_en", rc_en, 0);

    // R9 pass-through before failure, ref edges without failure
    sw_main = 1'b0; sw_mck = 2'd3; sw_rc = 1'b1;
    ref_edge();
    chk("R9 main_sel", main_sel, 0);
    chk("R9 mck_sel", mck_sel, 3);
    chk("R9 rc_en", rc_en, 1);
    chk("R9 done_o", done_o, 0);

    for (int v = 0; v < 6; v++) begin
      logic m, r;
      logic [1:0] mk, ne;
      {m, mk, r, ne} = VEC[v];
      sw_main = m; sw_mck = mk; sw_rc = r;
      do_reset();
      raise_fail();
      chk("R2 fail_o sticky", fail_o, 1);
      for (int k = 1; k <= 3; k++) begin
        ref_edge();
        // R3 R4 R7 main select; R4 mck select; R5 rc enable; R8 done
        chk("R3/R7 main_sel", main_sel, (ne != 0 && k >= ne) ? 0 : m);
        chk("R4 mck_sel", mck_sel, (ne == 3 && k >= 2) ? 1 : mk);
        chk("R5 rc_en", rc_en, (ne != 0) ? 1 : r);
        chk("R8 done_o", done_o, (ne != 0 && k >= ne) ? 1 : 0);
        chk("R2 fail_o", fail_o, 1);
      end
      if (ne == 0) begin
        // R7 outputs still follow software after ignored failure
        sw_main = 1'b1; sw_mck = 2'd0; sw_rc = 1'b0;
        @(negedge clk);
        chk("R7 main_sel", main_sel, 1);
        chk("R7 mck_sel", mck_sel, 0);
        chk("R7 rc_en", rc_en, 0);
      end else begin
        // R6 overrides ignore software after completion
        sw_main = 1'b1; sw_mck = 2'd2; sw_rc = 1'b0;
        ref_edge();
        chk("R6 main_sel", main_sel, 0);
        chk("R6 rc_en", rc_en, 0 + 1);
        chk("R6 mck_sel", mck_sel, (ne == 3) ? 1 : 2);
        chk("R8 done held", done_o, 1);
      end
    end

    // R3 failure captured, crystal path: after one edge main not yet forced
    sw_main = 1'b1; sw_mck = 2'd1; sw_rc = 1'b0;
    do_reset();
    raise_fail();
    ref_edge();
    chk("R3 first edge main_sel", main_sel, 1);
    chk("R5 first edge rc_en", rc_en, 1);
    // R1 reset clears latched state
    do_reset();
    @(negedge clk);
    chk("R1 fail cleared", fail_o, 0);
    chk("R1 main restored", main_sel, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule